// File: doc/BRIEF.md
# Page-Locked DMA Address Counter

This block produces the 24-bit memory address for a DMA channel and moves it by one transfer unit each time a step strobe arrives. The address has two parts. The upper part is a page that software supplies. The lower part is an offset that counts up or down. When the offset passes either end of its range it wraps back to the other end. It never carries into the page bits and never borrows from them, so a transfer block always stays inside the window it started in.

There are two transfer widths. For byte transfers the offset is bits 15:0 and each step moves the address by 1, which gives a 64 KB window. For word transfers the offset is bits 16:1 and each step moves the address by 2, which gives a 128 KB window. In word mode bit 0 and bits 23:17 are left alone. A load writes a new page and base offset. It is used at the start of each block, and the channel controller then pulses the step strobe once per completed transfer. Wrap-in-page is the only mode, so it is the behaviour from reset onward.

Top module: `dma_page_addr_gen`

## Requirements
- R1: While rst_ni is low, addr_o is 0.
- R2: When load_i is high at a clock edge, addr_o becomes {page_i, base_i} after that edge. page_i drives bits 23:16 and base_i drives bits 15:0.
- R3: When load_i and step_i are both high at the same edge, the load takes effect and the step is discarded.
- R4: When neither load_i nor step_i is high, addr_o holds its value, whatever dir_dn_i and wide_i do.
- R5: A step with wide_i=0 and dir_dn_i=0 replaces bits 15:0 with (bits 15:0 + 1) mod 2^16 and leaves bits 23:16 unchanged. For example, 01FFFFh becomes 010000h.
- R6: A step with wide_i=0 and dir_dn_i=1 replaces bits 15:0 with (bits 15:0 - 1) mod 2^16 and leaves bits 23:16 unchanged. For example, 020000h becomes 02FFFFh.
- R7: A step with wide_i=1 and dir_dn_i=0 replaces bits 16:1 with (bits 16:1 + 1) mod 2^16 and leaves bits 23:17 and bit 0 unchanged. For example, 01FFFEh becomes 000000h.
- R8: A step with wide_i=1 and dir_dn_i=1 replaces bits 16:1 with (bits 16:1 - 1) mod 2^16 and leaves bits 23:17 and bit 0 unchanged. For example, 020000h becomes 03FFFEh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load page and base offset |
| page_i | input | 8 | Page value, address bits 23:16 |
| base_i | input | 16 | Base offset, address bits 15:0 |
| dir_dn_i | input | 1 | Step direction: 1 counts down, 0 counts up |
| wide_i | input | 1 | Transfer width: 1 for 16-bit words, 0 for bytes |
| step_i | input | 1 | Advance by one transfer unit |
| addr_o | output | 24 | Current address |

## Verification
The properties assume that dir_dn_i and wide_i are valid whenever step_i is sampled. They also assume that a word-mode block begins from an even base, so that bit 0 has a meaning to keep. Nothing about alignment is enforced, because the design holds bit 0 whatever its value. The stimulus sets direction and width in the same cycle as each strobe. The directed wrap cases use even bases in word mode. The random stretch also mixes odd bases into word-mode steps, which shows that bit 0 passes through unchanged.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } step_dir_e;

  typedef enum logic {
    XFER_BYTE = 1'b0,
    XFER_WORD = 1'b1
  } xfer_w_e;

  localparam int unsigned N_WIN = 2;  // one counting window per transfer width
endpackage

// File: rtl/dma_addr_stepper.sv
module dma_addr_stepper
  import dma_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LOW_W  = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  step_dir_e         dir_i,
  input  xfer_w_e           width_i,
  output logic [ADDR_W-1:0] next_o
);
  localparam logic [LOW_W-1:0] ONE_N = LOW_W'(1);

  logic [ADDR_W-1:0] cand [N_WIN];

  // window g counts bits [g+LOW_W-1:g]; all other bits pass through
  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    logic [LOW_W-1:0] cnt_q;
    logic [LOW_W-1:0] cnt_d;
    always_comb begin
      cnt_q = addr_i[g +: LOW_W];
      cnt_d = (dir_i == DIR_DN) ? cnt_q - ONE_N : cnt_q + ONE_N;
      cand[g] = addr_i;
      cand[g][g +: LOW_W] = cnt_d;
    end
  end

  assign next_o = (width_i == XFER_WORD) ? cand[1] : cand[0];
endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] step_val_i,
  output logic [ADDR_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= load_val_i;  // load beats step
    else if (step_i) q_o <= step_val_i;
  end
endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
  import dma_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LOW_W  = 16,
  localparam int unsigned PAGE_W = ADDR_W - LOW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [LOW_W-1:0]  base_i,
  input  logic              dir_dn_i,
  input  logic              wide_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] step_val;

  dma_addr_stepper #(
    .ADDR_W(ADDR_W),
    .LOW_W (LOW_W)
  ) i_stepper (
    .addr_i (addr_o),
    .dir_i  (step_dir_e'(dir_dn_i)),
    .width_i(xfer_w_e'(wide_i)),
    .next_o (step_val)
  );

  dma_addr_reg #(
    .ADDR_W(ADDR_W)
  ) i_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .load_val_i({page_i, base_i}),
    .step_i    (step_i),
    .step_val_i(step_val),
    .q_o       (addr_o)
  );
endmodule

// File: rtl/dma_page_addr_chk.sv
module dma_page_addr_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LOW_W  = 16,
  localparam int unsigned PAGE_W = ADDR_W - LOW_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [PAGE_W-1:0] page_i,
  input logic [LOW_W-1:0]  base_i,
  input logic              dir_dn_i,
  input logic              wide_i,
  input logic              step_i,
  input logic [ADDR_W-1:0] addr_o
);
  localparam logic [LOW_W-1:0] ONE_N = LOW_W'(1);

  always_comb begin
    if (!rst_ni) AST_RESET_ZERO: assert (addr_o == '0);  // R1
  end

  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == {$past(page_i), $past(base_i)});  // R2

  AST_LOAD_OVER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && step_i) |=> addr_o == {$past(page_i), $past(base_i)});  // R3

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(addr_o));  // R4

  AST_BYTE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && !wide_i && !dir_dn_i) |=>
      addr_o[ADDR_W-1:LOW_W] == $past(addr_o[ADDR_W-1:LOW_W]) &&
      addr_o[LOW_W-1:0] == $past(addr_o[LOW_W-1:0]) + ONE_N);  // R5

  AST_BYTE_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && !wide_i && dir_dn_i) |=>
      addr_o[ADDR_W-1:LOW_W] == $past(addr_o[ADDR_W-1:LOW_W]) &&
      addr_o[LOW_W-1:0] == $past(addr_o[LOW_W-1:0]) - ONE_N);  // R6

  AST_WORD_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && wide_i && !dir_dn_i) |=>
      addr_o[ADDR_W-1:LOW_W+1] == $past(addr_o[ADDR_W-1:LOW_W+1]) &&
      addr_o[0] == $past(addr_o[0]) &&
      addr_o[LOW_W:1] == $past(addr_o[LOW_W:1]) + ONE_N);  // R7

  AST_WORD_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && wide_i && dir_dn_i) |=>
      addr_o[ADDR_W-1:LOW_W+1] == $past(addr_o[ADDR_W-1:LOW_W+1]) &&
      addr_o[0] == $past(addr_o[0]) &&
      addr_o[LOW_W:1] == $past(addr_o[LOW_W:1]) - ONE_N);  // R8
endmodule

bind dma_page_addr_gen dma_page_addr_chk #(
  .ADDR_W(ADDR_W),
  .LOW_W (LOW_W)
) i_chk (.*);

// File: tb/test_dma_page_addr_gen.sv
`timescale 1ns/1ps
module test_dma_page_addr_gen;
  typedef struct {
    logic [23:0] exp;
    string       req;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [7:0]  page_i = '0;
  logic [15:0] base_i = '0;
  logic        dir_dn_i = 1'b0;
  logic        wide_i = 1'b0;
  logic        step_i = 1'b0;
  logic [23:0] addr_o;

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  item_t sb_q[$];
  logic [23:0] model = '0;

  always #2 clk_i = ~clk_i;

  dma_page_addr_gen i_dma_page_addr_gen (.*);

  // reference next address taken from the requirements
  function automatic logic [23:0] ref_step(logic [23:0] a, logic dn, logic wd);
    logic [15:0] c;
    if (!wd) begin
      c = dn ? a[15:0] - 16'd1 : a[15:0] + 16'd1;
      return {a[23:16], c};
    end
    c = dn ? a[16:1] - 16'd1 : a[16:1] + 16'd1;
    return {a[23:17], c, a[0]};
  endfunction

  task automatic drive(logic ld, logic [7:0] pg, logic [15:0] bs,
                       logic dn, logic wd, logic st, string req);
    item_t it;
    @(negedge clk_i);
    load_i = ld; page_i = pg; base_i = bs;
    dir_dn_i = dn; wide_i = wd; step_i = st;
    if (ld) model = {pg, bs};
    else if (st) model = ref_step(model, dn, wd);
    @(posedge clk_i);
    #1;
    it.exp = model;
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: compare each result one step after the edge that made it
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_run++;
        if (addr_o !== it.exp) begin
          n_fail++;
          $display("FAIL %s: addr_o=%06h expected %06h", it.req, addr_o, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset value
    #7;
    n_run++;
    if (addr_o !== 24'h0) begin
      n_fail++;
      $display("FAIL R1: addr_o=%06h expected 000000", addr_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 load, then R5 byte up across the top of the window
    drive(1, 8'h01, 16'hFFFF, 0, 0, 0, "R2");
    drive(0, 8'h00, 16'h0000, 0, 0, 1, "R5");
    drive(0, 8'h00, 16'h0000, 0, 0, 1, "R5");
    // R6 byte down across the bottom
    drive(1, 8'h02, 16'h0000, 0, 0, 0, "R2");
    drive(0, 8'h00, 16'h0000, 1, 0, 1, "R6");
    drive(0, 8'h00, 16'h0000, 1, 0, 1, "R6");
    // R4 idle with direction and width toggling
    drive(0, 8'hAA, 16'h5555, 0, 1, 0, "R4");
    drive(0, 8'h55, 16'hAAAA, 1, 0, 0, "R4");
    drive(0, 8'h00, 16'h0000, 1, 1, 0, "R4");
    // R7 word up: 01FFFE -> 000000
    drive(1, 8'h01, 16'hFFFE, 0, 1, 0, "R2");
    drive(0, 8'h00, 16'h0000, 0, 1, 1, "R7");
    drive(0, 8'h00, 16'h0000, 0, 1, 1, "R7");
    // R8 word down: 020000 -> 03FFFE
    drive(1, 8'h02, 16'h0000, 1, 1, 0, "R2");
    drive(0, 8'h00, 16'h0000, 1, 1, 1, "R8");
    drive(0, 8'h00, 16'h0000, 1, 1, 1, "R8");
    // R3 load with simultaneous step
    drive(1, 8'h7C, 16'h1234, 0, 0, 1, "R3");
    drive(1, 8'hFF, 16'hFFFF, 1, 1, 1, "R3");
    // R8 word down with odd bit 0 kept
    drive(1, 8'h04, 16'h0001, 1, 1, 0, "R2");
    drive(0, 8'h00, 16'h0000, 1, 1, 1, "R8");

    // mixed random stretch
    for (int i = 0; i < 400; i++) begin
      logic ld, st, dn, wd;
      string r;
      ld = ($urandom % 8) == 0;
      st = ($urandom % 4) != 0;
      dn = 1'($urandom);
      wd = 1'($urandom);
      if (ld) r = st ? "R3" : "R2";
      else if (!st) r = "R4";
      else if (!wd) r = dn ? "R6" : "R5";
      else r = dn ? "R8" : "R7";
      drive(ld, 8'($urandom), 16'($urandom), dn, wd, st, r);
    end

    @(negedge clk_i);
    step_i = 1'b0;
    load_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #3;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule